// File: doc/BRIEF.md
# Charge Pump Speed-up Controller

This block produces the digital current-setting codes for the three charge pumps of a dual-loop frequency synthesizer. The main loop has a proportional pump and an integral pump; the auxiliary loop has one pump. A 2-bit gain selector sets the pump currents. Its upper bit also removes the integral pump from service.

Each code is an integer count of half-units of the charge-pump bias current. For example, 36 times the bias current is encoded as 72.

After a new frequency word is loaded, the block opens a speed-up window. The window lasts exactly as long as the next strobe pulse, so the host sets the window length by holding the strobe for a chosen number of its own clock cycles. While the window is open, the proportional pump switches to its boosted value and the integral pump is driven. Outside the window the integral pump is idle.

Two configuration bits override the strobe timing. One keeps speed-up on continuously. The other blocks speed-up entirely, and it wins over the first and over the window.

Top module: `cp_speedup_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are `spu_active`=0, `aux_code`=3, `prop_code`=6 and `integ_code`=0.
- R2: Outside speed-up, the gain selector sets the codes as follows, and `integ_code` is 0 for every selector value.
  - 00: `aux_code`=3, `prop_code`=6
  - 01: `aux_code`=1, `prop_code`=2
  - 10: `aux_code`=3, `prop_code`=6
  - 11: `aux_code`=1, `prop_code`=2
- R3: During speed-up, the gain selector sets the codes as follows. `aux_code` keeps its R2 value.
  - 00: `prop_code`=30, `integ_code`=72
  - 01: `prop_code`=10, `integ_code`=24
  - 10: `prop_code`=30, `integ_code`=0
  - 11: `prop_code`=10, `integ_code`=0
- R4: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge.
- R5: After a cycle with `aword_load`=1, the first cycle in which `strobe` is sampled high after being sampled low opens the window. `spu_active` then stays 1 for each cycle that `strobe` is sampled high.
- R6: The window closes in the first cycle that `strobe` is sampled low. A later strobe pulse with no new load does not reopen it.
- R7: If `strobe` is sampled high in the load cycle, or is already high then, that pulse is ignored. Only a later low-to-high transition opens the window.
- R8: While `force_spu`=1, speed-up is active whatever the strobe and load history.
- R9: While `block_spu`=1, speed-up is inactive. This overrides both `force_spu` and an open window, and the window itself is not closed by the block.
- R10: A load while the window is open closes the window and re-arms it for the next strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gain_sel | input | 2 | Pump gain selector; the upper bit disables the integral pump |
| force_spu | input | 1 | Keep speed-up on continuously |
| block_spu | input | 1 | Prevent speed-up |
| aword_load | input | 1 | One-cycle flag: a new frequency word was loaded |
| strobe | input | 1 | Strobe line; its width after a load sets the window |
| aux_code | output | 7 | Auxiliary pump current, half-units of bias |
| prop_code | output | 7 | Main proportional pump current, half-units |
| integ_code | output | 7 | Main integral pump current, half-units |
| spu_active | output | 1 | Speed-up currently applied |

## Verification
The window state machine is internal, so its faults show only through `spu_active`, `prop_code` and `integ_code`. A fault becomes visible one clock after the strobe sample that should change the state. Examples are a stale armed state, a window that survives a strobe fall, and a pulse that was high at load being accepted. A wrong gain map shows in the same cycle the selector is applied. The block/force priority is visible only when both bits are set together, so the directed scenarios set them together.

// File: rtl/cpsu_pkg.sv
// Package: shared types and widths for the charge pump speed-up controller.
// Assumes: codes are unsigned half-units of the bias current.
package cpsu_pkg;
    localparam int unsigned CODE_W = 7;
    localparam int unsigned GAIN_W = 2;

    typedef enum logic [1:0] {
        WIN_IDLE  = 2'd0,
        WIN_ARMED = 2'd1,
        WIN_OPEN  = 2'd2
    } win_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] aux;
        logic [CODE_W-1:0] prop;
        logic [CODE_W-1:0] integ;
    } pump_codes_t;
endpackage

// File: rtl/cpsu_strobe_edge.sv
// Module: registers the strobe and flags its rising and falling transitions.
// Assumes: strobe is already synchronous to clk.
module cpsu_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise,
    output logic fall
);
    logic strb_q;

    // Hold last sampled strobe level; reset treats it as low.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_q <= 1'b0;
        else        strb_q <= strobe;
    end

    // Compare present level with the previous sample.
    always_comb begin
        rise = strobe & ~strb_q;
        fall = ~strobe & strb_q;
    end

    assert_edges_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));
endmodule

// File: rtl/cpsu_window_fsm.sv
// Module: speed-up window tracker. A load arms it, the next strobe rise
// opens it and the following strobe fall closes it.
// Assumes: load has priority over edges in the same cycle.
module cpsu_window_fsm
    import cpsu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic rise,
    input  logic fall,
    output logic win_next
);
    win_state_t state_q, state_d;

    // Next-state selection; a load always re-arms.
    always_comb begin
        state_d = state_q;
        if (load) begin
            state_d = WIN_ARMED;
        end else begin
            case (state_q)
                WIN_ARMED: if (rise) state_d = WIN_OPEN;
                WIN_OPEN:  if (fall) state_d = WIN_IDLE;
                default:   state_d = WIN_IDLE;
            endcase
        end
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    // Window level as it will be after this edge.
    always_comb win_next = (state_d == WIN_OPEN);

    assert_fall_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_OPEN && fall && !load) |=> (state_q == WIN_IDLE));
    assert_armed_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_ARMED && !rise && !load) |=> (state_q == WIN_ARMED));
    assert_load_rearms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (state_q == WIN_ARMED));
    assert_idle_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WIN_IDLE && !load) |=> (state_q == WIN_IDLE));
endmodule

// File: rtl/cpsu_mode_arb.sv
// Module: resolves the speed-up request from the window, the force bit and the block bit.
// Assumes: block has the highest priority.
module cpsu_mode_arb (
    input  logic win_open,
    input  logic force_on,
    input  logic block_on,
    output logic spu
);
    // Priority: block, then force, then the strobe window.
    always_comb begin
        if (block_on)      spu = 1'b0;
        else if (force_on) spu = 1'b1;
        else               spu = win_open;
    end
endmodule

// File: rtl/cpsu_gain_map.sv
// Module: maps the gain selector and speed-up state to pump codes.
// Assumes: low gain is the high gain divided by LOW_DIV exactly;
//          the selector's upper bit turns the integral pump off.
module cpsu_gain_map
    import cpsu_pkg::*;
#(
    parameter int unsigned AUX_HI   = 3,
    parameter int unsigned PROP_HI  = 6,
    parameter int unsigned SPU_MULT = 5,
    parameter int unsigned INT_MULT = 12,
    parameter int unsigned LOW_DIV  = 3
) (
    input  logic [GAIN_W-1:0] gain,
    input  logic              spu,
    output pump_codes_t       codes
);
    localparam int unsigned NSEL    = 1 << GAIN_W;
    localparam int unsigned PSU_HI  = PROP_HI * SPU_MULT;
    localparam int unsigned INT_HI  = PROP_HI * INT_MULT;

    logic [CODE_W-1:0] aux_tbl   [NSEL];
    logic [CODE_W-1:0] prop_tbl  [NSEL];
    logic [CODE_W-1:0] psu_tbl   [NSEL];
    logic [CODE_W-1:0] integ_tbl [NSEL];

    // One table row per selector value; bit 0 picks the divided-down set.
    for (genvar g = 0; g < NSEL; g++) begin : g_row
        localparam int unsigned DIV = ((g % 2) == 1) ? LOW_DIV : 1;
        localparam bit INT_ON = (g < NSEL / 2);
        assign aux_tbl[g]   = CODE_W'(AUX_HI / DIV);
        assign prop_tbl[g]  = CODE_W'(PROP_HI / DIV);
        assign psu_tbl[g]   = CODE_W'(PSU_HI / DIV);
        assign integ_tbl[g] = INT_ON ? CODE_W'(INT_HI / DIV) : '0;
    end

    // Pick row, then choose boosted or normal values.
    always_comb begin
        codes.aux   = aux_tbl[gain];
        codes.prop  = spu ? psu_tbl[gain] : prop_tbl[gain];
        codes.integ = spu ? integ_tbl[gain] : '0;
    end
endmodule

// File: rtl/cp_speedup_ctrl.sv
// Module: top of the charge pump speed-up controller. Outputs are registered
// and reflect the inputs sampled at the previous edge.
// Assumes: all inputs are synchronous to clk; aword_load is a one-cycle pulse.
module cp_speedup_ctrl
    import cpsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] gain_sel,
    input  logic              force_spu,
    input  logic              block_spu,
    input  logic              aword_load,
    input  logic              strobe,
    output logic [CODE_W-1:0] aux_code,
    output logic [CODE_W-1:0] prop_code,
    output logic [CODE_W-1:0] integ_code,
    output logic              spu_active
);
    logic        rise, fall, win_next, spu_d;
    pump_codes_t codes_d;

    cpsu_strobe_edge u_edge (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .rise(rise), .fall(fall)
    );

    cpsu_window_fsm u_win (
        .clk(clk), .rst_n(rst_n), .load(aword_load),
        .rise(rise), .fall(fall), .win_next(win_next)
    );

    cpsu_mode_arb u_arb (
        .win_open(win_next), .force_on(force_spu), .block_on(block_spu), .spu(spu_d)
    );

    cpsu_gain_map u_map (
        .gain(gain_sel), .spu(spu_d), .codes(codes_d)
    );

    // Output registers; reset selects selector-00 normal values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spu_active <= 1'b0;
            aux_code   <= CODE_W'(3);
            prop_code  <= CODE_W'(6);
            integ_code <= '0;
        end else begin
            spu_active <= spu_d;
            aux_code   <= codes_d.aux;
            prop_code  <= codes_d.prop;
            integ_code <= codes_d.integ;
        end
    end

    assert_integ_only_in_spu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (integ_code != '0) |-> spu_active);
    assert_block_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        block_spu |=> !spu_active);
    assert_force_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_spu && !block_spu) |=> spu_active);
    assert_prop_above_aux_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prop_code > aux_code);
endmodule

// File: tb/sim_cp_speedup_ctrl.sv
module sim_cp_speedup_ctrl;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] gain_sel = 2'b00;
    logic       force_spu = 1'b0, block_spu = 1'b0, aword_load = 1'b0, strobe = 1'b0;
    logic [6:0] aux_code, prop_code, integ_code;
    logic       spu_active;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    cp_speedup_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .gain_sel(gain_sel), .force_spu(force_spu),
        .block_spu(block_spu), .aword_load(aword_load), .strobe(strobe),
        .aux_code(aux_code), .prop_code(prop_code), .integ_code(integ_code),
        .spu_active(spu_active)
    );

    // Advance one edge; sample afterwards at the falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare all outputs against values derived from the requirement tables.
    task automatic expect_out(string req, logic [1:0] g, bit s);
        int a, p, i;
        a = g[0] ? 1 : 3;
        p = s ? (g[0] ? 10 : 30) : (g[0] ? 2 : 6);
        i = (s && !g[1]) ? (g[0] ? 24 : 72) : 0;
        check({req, " spu"}, int'(spu_active), int'(s));
        check({req, " aux"}, int'(aux_code), a);
        check({req, " prop"}, int'(prop_code), p);
        check({req, " integ"}, int'(integ_code), i);
    endtask

    task automatic t_reset_r1();
        rst_n = 1'b0; gain_sel = 2'b11; force_spu = 1'b1; strobe = 1'b1;
        step();
        check("R1 spu", int'(spu_active), 0);
        check("R1 aux", int'(aux_code), 3);
        check("R1 prop", int'(prop_code), 6);
        check("R1 integ", int'(integ_code), 0);
        force_spu = 1'b0; strobe = 1'b0; gain_sel = 2'b00;
        step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_table_r2();
        for (int g = 0; g < 4; g++) begin
            gain_sel = 2'(g);
            step();
            expect_out("R2", 2'(g), 1'b0);
        end
    endtask

    task automatic t_force_r3_r8();
        force_spu = 1'b1;
        for (int g = 0; g < 4; g++) begin
            gain_sel = 2'(g);
            step();
            expect_out("R3/R8", 2'(g), 1'b1);
        end
        force_spu = 1'b0; gain_sel = 2'b00;
        step();
        expect_out("R8 release", 2'b00, 1'b0);
    endtask

    task automatic t_auto_r5_r6();
        gain_sel = 2'b00;
        aword_load = 1'b1;
        step();
        expect_out("R5 load", 2'b00, 1'b0);
        aword_load = 1'b0; strobe = 1'b1;
        step();
        expect_out("R4/R5 open", 2'b00, 1'b1);
        for (int k = 0; k < 3; k++) begin
            step();
            expect_out("R5 hold", 2'b00, 1'b1);
        end
        strobe = 1'b0;
        step();
        expect_out("R6 close", 2'b00, 1'b0);
        strobe = 1'b1;
        step();
        expect_out("R6 no reopen", 2'b00, 1'b0);
        strobe = 1'b0;
        step();
    endtask

    task automatic t_prehigh_r7();
        gain_sel = 2'b01;
        strobe = 1'b1; aword_load = 1'b1;
        step();
        expect_out("R7 load high", 2'b01, 1'b0);
        aword_load = 1'b0;
        step();
        step();
        expect_out("R7 ignored", 2'b01, 1'b0);
        strobe = 1'b0;
        step();
        expect_out("R7 low", 2'b01, 1'b0);
        strobe = 1'b1;
        step();
        expect_out("R7 new rise", 2'b01, 1'b1);
        strobe = 1'b0;
        step();
        expect_out("R7 close", 2'b01, 1'b0);
    endtask

    task automatic t_block_r9();
        gain_sel = 2'b00;
        force_spu = 1'b1; block_spu = 1'b1;
        step();
        expect_out("R9 over force", 2'b00, 1'b0);
        force_spu = 1'b0;
        aword_load = 1'b1;
        step();
        aword_load = 1'b0; strobe = 1'b1;
        step();
        expect_out("R9 over window", 2'b00, 1'b0);
        block_spu = 1'b0;
        step();
        expect_out("R9 window kept", 2'b00, 1'b1);
        strobe = 1'b0;
        step();
        expect_out("R9 close", 2'b00, 1'b0);
    endtask

    task automatic t_reload_r10();
        gain_sel = 2'b10;
        aword_load = 1'b1;
        step();
        aword_load = 1'b0; strobe = 1'b1;
        step();
        expect_out("R10 open", 2'b10, 1'b1);
        aword_load = 1'b1;
        step();
        expect_out("R10 reload", 2'b10, 1'b0);
        aword_load = 1'b0;
        step();
        expect_out("R10 armed", 2'b10, 1'b0);
        strobe = 1'b0;
        step();
        strobe = 1'b1;
        step();
        expect_out("R10 reopen", 2'b10, 1'b1);
        strobe = 1'b0;
        step();
        expect_out("R10 close", 2'b10, 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_r1();
        t_table_r2();
        t_force_r3_r8();
        t_auto_r5_r6();
        t_prehigh_r7();
        t_block_r9();
        t_reload_r10();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule